// File: doc/BRIEF.md
# Multi-Page-Size TLB Lookup Unit

This block is the lookup stage of an address translation unit. It is a fully associative table of 64 entries. Each entry holds a tag word, which carries a virtual page number and a 13-bit context, and a translation word, which carries a valid flag, a page-size code, a physical page number and permission bits. Every entry is compared against the virtual address and the current context in the same lookup. Each entry selects its own compare mask from its size code, so pages of 8 KB, 64 KB, 512 KB and 4 MB can share the table.

A lookup returns one of four outcomes in the cycle after the request. A permitted hit returns the merged physical address and a permission set. A protection fault is reported when the hit entry forbids the access. A miss loads a tag-access register with the page-aligned virtual address and the context. In bypass, the address passes through untranslated. Software fills the table through a single write port. A parameter selects the data-side or the instruction-side flavour. The two flavours differ in the store-permission check, in the permission set returned, and in whether the reset/error state forces bypass.

Top module: `tlb_xlate_unit`

## Requirements
- R1: Reset clears every entry's valid flag, all response outputs and the tag-access register. A lookup after reset misses until an entry is written again.
- R2: Each cycle with `req_valid` high produces exactly one response in the next cycle, with `rsp_valid` high and at most one of `rsp_hit`, `rsp_fault` and `rsp_miss` set. `rsp_valid` is low in a cycle that follows no request.
- R3: Bits 62:61 of the translation word choose the page size: 0 means 8 KB, 1 means 64 KB, 2 means 512 KB and 3 means 4 MB. For that entry, the virtual address is compared with the tag word with the low 13, 16, 19 or 22 bits ignored.
- R4: An entry can only match when bit 63 of its translation word is 1.
- R5: An entry can only match when `cur_ctx` equals bits 12:0 of its tag word.
- R6: On a hit, the physical address takes the translation word's bits above the page offset and the virtual address's bits inside the page offset. It then keeps only bits 40:13, so `rsp_pa[12:0]` is zero.
- R7: When several entries match, the entry with the lowest index is used.
- R8: A user access (`req_user`=1) that matches an entry whose bit 2 is set is a protection fault. A fault reports `rsp_perm`=0 and `rsp_pa`=0.
- R9: Data configuration (`IS_INSTR`=0): a store (`req_kind`=1) that matches an entry whose bit 1 is clear is a protection fault. A permitted hit returns `rsp_perm` bit 0 (read), plus bit 1 (write) when the entry's bit 1 is set. Loads (`req_kind`=0) and fetches (`req_kind`=2) skip the write check.
- R10: Instruction configuration (`IS_INSTR`=1): the write check is skipped for every access kind, and a permitted hit returns only `rsp_perm` bit 2 (execute).
- R11: On a miss, `rsp_miss` is set and `tag_access` becomes the virtual address with bits 12:0 replaced by `cur_ctx`, with `rsp_pa`=0 and `rsp_perm`=0. On any other outcome, `tag_access` keeps its value.
- R12: With `xlate_en` low, or in the instruction configuration with `red_state` high, the lookup is bypassed. The response is then `rsp_pa` = `req_va[40:0]`, `rsp_perm` = 3'b011 (data) or 3'b100 (instruction), no hit, fault or miss flag, and no change to `tag_access`.
- R13: A write with `wr_en` high replaces entry `wr_idx` at the next clock edge. A lookup issued in the same cycle as the write still sees the old contents of that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_tag | input | 64 | Tag word to store |
| wr_tte | input | 64 | Translation word to store |
| xlate_en | input | 1 | Translation enable; low selects bypass |
| red_state | input | 1 | Processor in reset/error state (forces bypass on the instruction side) |
| cur_ctx | input | 13 | Current context number |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 41 | Physical address |
| rsp_hit | output | 1 | Permitted hit |
| rsp_fault | output | 1 | Protection fault on a matching entry |
| rsp_miss | output | 1 | No entry matched |
| rsp_perm | output | 3 | Granted permissions: bit 0 read, bit 1 write, bit 2 execute |
| tag_access | output | 64 | Tag-access value captured on the last miss |

## Verification
The checks assume that reset is held for at least two clock edges, so that every `$past` sample after reset reads a defined value. They also assume that `req_kind` never takes the value 3. The stimulus keeps both assumptions: it holds reset for five cycles and drives only the three defined access kinds. The bench compares each response with a model of the table in the bench. It drives data-side and instruction-side instances in parallel with the same stimulus, so that each difference between the flavours shows up on the same request.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

  localparam int WORD_W     = 64;
  localparam int BASE_SHIFT = 13;  // smallest page offset width

  // translation word field positions (decoded by the lookup logic)
  localparam int TTE_VALID_BIT = 63;
  localparam int TTE_SZ_HI     = 62;
  localparam int TTE_SZ_LO     = 61;
  localparam int TTE_PRIV_BIT  = 2;
  localparam int TTE_WR_BIT    = 1;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2
  } acc_kind_e;

  typedef logic [1:0] psize_t;

  localparam logic [2:0] PERM_READ  = 3'b001;
  localparam logic [2:0] PERM_WRITE = 3'b010;
  localparam logic [2:0] PERM_EXEC  = 3'b100;

  // each size step widens the page offset by three bits
  function automatic logic [WORD_W-1:0] page_mask(input psize_t sz);
    logic [5:0] sh;
    sh = 6'(BASE_SHIFT) + 6'({4'd0, sz} * 6'd3);
    return ~((64'd1 << sh) - 64'd1);
  endfunction

endpackage

// File: rtl/tlbx_entry_store.sv
module tlbx_entry_store
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_tag,
  input  logic [WORD_W-1:0] wr_tte,
  output logic [WORD_W-1:0] tag_o   [ENTRIES],
  output logic [WORD_W-1:0] tte_o   [ENTRIES],
  output psize_t            psize_o [ENTRIES],
  output logic [ENTRIES-1:0] valid_o
);

  // payload words: no reset, written one entry per cycle
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_o[wr_idx] <= wr_tag;
      tte_o[wr_idx] <= wr_tte;
    end
  end

  // valid flags kept apart so reset can clear them all at once
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= '0;
    end else if (wr_en) begin
      valid_o[wr_idx] <= wr_tte[TTE_VALID_BIT];
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_size
    assign psize_o[g] = tte_o[g][TTE_SZ_HI:TTE_SZ_LO];
  end

  // R13: the written valid flag is visible after one edge
  a_r13_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (valid_o[$past(wr_idx)] == $past(wr_tte[TTE_VALID_BIT])));

endmodule

// File: rtl/tlbx_match_array.sv
module tlbx_match_array
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int CTX_W   = 13
) (
  input  logic [WORD_W-1:0]  tag_i   [ENTRIES],
  input  psize_t             psize_i [ENTRIES],
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [WORD_W-1:0]  va_i,
  input  logic [CTX_W-1:0]   ctx_i,
  output logic [ENTRIES-1:0] hit_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [WORD_W-1:0] cmask;
    logic              ctx_eq;
    logic              va_eq;
    assign cmask    = page_mask(psize_i[g]);
    assign ctx_eq   = (tag_i[g][CTX_W-1:0] == ctx_i);
    assign va_eq    = ((va_i & cmask) == (tag_i[g] & cmask));
    assign hit_o[g] = valid_i[g] && ctx_eq && va_eq;
  end

endmodule

// File: rtl/tlbx_prio_pick.sv
module tlbx_prio_pick #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hit_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);

  always_comb begin
    any_o = |hit_i;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IDX_W'(i);
    end
  end

  // R7: chosen entry matches and no lower entry matches
  always_comb begin
    if (any_o) begin
      a_r7_pick_is_hit: assert (hit_i[idx_o]);
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (any_o && (i < int'(idx_o))) begin
        a_r7_lowest_wins: assert (!hit_i[i]);
      end
    end
  end

endmodule

// File: rtl/tlb_xlate_unit.sv
module tlb_xlate_unit
  import tlbx_pkg::*;
#(
  parameter int ENTRIES  = 64,
  parameter int CTX_W    = 13,
  parameter int PA_W     = 41,
  parameter int IS_INSTR = 0,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [63:0]       wr_tag,
  input  logic [63:0]       wr_tte,
  input  logic              xlate_en,
  input  logic              red_state,
  input  logic [CTX_W-1:0]  cur_ctx,
  input  logic              req_valid,
  input  logic [63:0]       req_va,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic              rsp_miss,
  output logic [2:0]        rsp_perm,
  output logic [63:0]       tag_access
);

  localparam logic IS_I = (IS_INSTR != 0);
  localparam logic [WORD_W-1:0] LOW_MASK = (64'd1 << BASE_SHIFT) - 64'd1;
  localparam logic [WORD_W-1:0] PA_KEEP  = ((64'd1 << PA_W) - 64'd1) & ~LOW_MASK;
  localparam logic [2:0] BYP_PERM = IS_I ? PERM_EXEC : (PERM_READ | PERM_WRITE);

  logic [WORD_W-1:0]  tag_arr   [ENTRIES];
  logic [WORD_W-1:0]  tte_arr   [ENTRIES];
  psize_t             psize_arr [ENTRIES];
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] hit_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   sel_idx;

  tlbx_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_tag  (wr_tag),
    .wr_tte  (wr_tte),
    .tag_o   (tag_arr),
    .tte_o   (tte_arr),
    .psize_o (psize_arr),
    .valid_o (valid_vec)
  );

  tlbx_match_array #(.ENTRIES(ENTRIES), .CTX_W(CTX_W)) u_match (
    .tag_i   (tag_arr),
    .psize_i (psize_arr),
    .valid_i (valid_vec),
    .va_i    (req_va),
    .ctx_i   (cur_ctx),
    .hit_o   (hit_vec)
  );

  tlbx_prio_pick #(.ENTRIES(ENTRIES)) u_pick (
    .hit_i (hit_vec),
    .any_o (any_hit),
    .idx_o (sel_idx)
  );

  // ---- evaluation of the selected entry ----
  logic [WORD_W-1:0] sel_tte;
  logic [WORD_W-1:0] sel_mask;
  logic [PA_W-1:0]   xl_pa;
  logic              bypass;
  logic              user_fault;
  logic              wr_fault;
  logic [2:0]        grant_perm;

  assign sel_tte    = tte_arr[sel_idx];
  assign sel_mask   = page_mask(sel_tte[TTE_SZ_HI:TTE_SZ_LO]);
  assign xl_pa      = PA_W'(((sel_tte & sel_mask) | (req_va & ~sel_mask)) & PA_KEEP);
  assign bypass     = !xlate_en || (IS_I && red_state);
  assign user_fault = sel_tte[TTE_PRIV_BIT] && req_user;

  if (IS_INSTR != 0) begin : g_instr
    assign wr_fault   = 1'b0;
    assign grant_perm = PERM_EXEC;
  end else begin : g_data
    assign wr_fault   = (req_kind == KIND_STORE) && !sel_tte[TTE_WR_BIT];
    assign grant_perm = PERM_READ | (sel_tte[TTE_WR_BIT] ? PERM_WRITE : 3'b000);
  end

  logic            n_hit, n_fault, n_miss;
  logic [PA_W-1:0] n_pa;
  logic [2:0]      n_perm;

  always_comb begin
    n_hit   = 1'b0;
    n_fault = 1'b0;
    n_miss  = 1'b0;
    n_pa    = '0;
    n_perm  = '0;
    if (req_valid) begin
      if (bypass) begin
        n_pa   = req_va[PA_W-1:0];
        n_perm = BYP_PERM;
      end else if (!any_hit) begin
        n_miss = 1'b1;
      end else if (user_fault || wr_fault) begin
        n_fault = 1'b1;
      end else begin
        n_hit  = 1'b1;
        n_pa   = xl_pa;
        n_perm = grant_perm;
      end
    end
  end

  // ---- registered response ----
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_pa    <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= n_hit;
      rsp_fault <= n_fault;
      rsp_miss  <= n_miss;
      rsp_pa    <= n_pa;
      rsp_perm  <= n_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_access <= '0;
    end else if (n_miss) begin
      tag_access <= (req_va & ~LOW_MASK) | 64'(cur_ctx);
    end
  end

  // ---- assertions ----
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_hit, rsp_fault, rsp_miss}));
  a_r6_offset_clear: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_pa[BASE_SHIFT-1:0] == '0));
  a_r8_fault_no_perm: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_perm == 3'b000));
  a_r11_ctx_captured: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (tag_access[CTX_W-1:0] == $past(cur_ctx)));
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !rsp_miss |-> $stable(tag_access));

  if (IS_INSTR != 0) begin : g_instr_chk
    a_r10_no_write_perm: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> !rsp_perm[1]);
  end

endmodule

// File: tb/tlb_xlate_unit_tb_top.sv
module tlb_xlate_unit_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, wr_en, xlate_en, red_state, req_valid, req_user;
  logic [5:0]  wr_idx;
  logic [63:0] wr_tag, wr_tte, req_va;
  logic [12:0] cur_ctx;
  logic [1:0]  req_kind;

  logic        d_valid, d_hit, d_fault, d_miss, i_valid, i_hit, i_fault, i_miss;
  logic [40:0] d_pa, i_pa;
  logic [2:0]  d_perm, i_perm;
  logic [63:0] d_ta, i_ta;

  tlb_xlate_unit #(.IS_INSTR(0)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tte(wr_tte),
    .xlate_en(xlate_en), .red_state(red_state), .cur_ctx(cur_ctx), .req_valid(req_valid),
    .req_va(req_va), .req_kind(req_kind), .req_user(req_user), .rsp_valid(d_valid),
    .rsp_pa(d_pa), .rsp_hit(d_hit), .rsp_fault(d_fault), .rsp_miss(d_miss),
    .rsp_perm(d_perm), .tag_access(d_ta));

  tlb_xlate_unit #(.IS_INSTR(1)) dut_instr_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tte(wr_tte),
    .xlate_en(xlate_en), .red_state(red_state), .cur_ctx(cur_ctx), .req_valid(req_valid),
    .req_va(req_va), .req_kind(req_kind), .req_user(req_user), .rsp_valid(i_valid),
    .rsp_pa(i_pa), .rsp_hit(i_hit), .rsp_fault(i_fault), .rsp_miss(i_miss),
    .rsp_perm(i_perm), .tag_access(i_ta));

  typedef struct {
    logic [40:0] pa;
    logic        hit, fault, miss;
    logic [2:0]  perm;
    logic [63:0] ta;
    string       req;
  } exp_t;

  exp_t q_d[$];
  exp_t q_i[$];

  logic [63:0] m_tag [64];
  logic [63:0] m_tte [64];
  bit          m_val [64];
  logic [63:0] m_ta  [2];
  int n_chk = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;

  localparam logic [12:0] CX = 13'h0AB;

  function automatic logic [63:0] ref_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 64'hFFFF_FFFF_FFFF_E000;
      2'd1:    return 64'hFFFF_FFFF_FFFF_0000;
      2'd2:    return 64'hFFFF_FFFF_FFF8_0000;
      default: return 64'hFFFF_FFFF_FFC0_0000;
    endcase
  endfunction

  function automatic logic [63:0] mk_tag(input logic [63:0] va, input logic [12:0] cx);
    return {va[63:13], cx};
  endfunction

  function automatic logic [63:0] mk_tte(input bit v, input logic [1:0] sz,
                                         input logic [63:0] pa, input bit pv, input bit wp);
    return {v, sz, 61'd0} | (pa & 64'h1FFF_FFFF_FFFF_E000) | {61'd0, pv, wp, 1'b0};
  endfunction

  function automatic exp_t ref_lookup(input int side, input logic [63:0] va,
                                      input logic [1:0] kind, input logic usr,
                                      input logic xen, input logic red,
                                      input logic [12:0] cx, input string req);
    exp_t e;
    int w;
    logic [63:0] mk, t, p;
    e.pa = '0; e.hit = 0; e.fault = 0; e.miss = 0; e.perm = '0; e.req = req;
    w = -1;
    if (!xen || (side == 1 && red)) begin
      e.pa = va[40:0];
      e.perm = (side == 1) ? 3'b100 : 3'b011;
      e.ta = m_ta[side];
      return e;
    end
    for (int i = 0; i < 64; i++) begin
      mk = ref_mask(m_tte[i][62:61]);
      if (w < 0 && m_val[i] && m_tag[i][12:0] == cx && ((va & mk) == (m_tag[i] & mk)))
        w = i;
    end
    if (w < 0) begin
      m_ta[side] = {va[63:13], cx};
      e.miss = 1;
      e.ta = m_ta[side];
      return e;
    end
    t = m_tte[w];
    mk = ref_mask(t[62:61]);
    if ((t[2] && usr) || (side == 0 && kind == 2'd1 && !t[1])) begin
      e.fault = 1;
    end else begin
      e.hit = 1;
      p = ((t & mk) | (va & ~mk)) & 64'h0000_01FF_FFFF_E000;
      e.pa = p[40:0];
      e.perm = (side == 1) ? 3'b100 : {1'b0, t[1], 1'b1};
    end
    e.ta = m_ta[side];
    return e;
  endfunction

  function automatic void model_write(input int idx, input logic [63:0] tg, input logic [63:0] te);
    m_tag[idx] = tg;
    m_tte[idx] = te;
    m_val[idx] = te[63];
  endfunction

  task automatic write_entry(input int idx, input logic [63:0] tg, input logic [63:0] te);
    @(negedge clk);
    req_valid = 0;
    wr_en = 1; wr_idx = 6'(idx); wr_tag = tg; wr_tte = te;
    model_write(idx, tg, te);
  endtask

  task automatic lookup(input logic [63:0] va, input logic [1:0] kind, input logic usr,
                        input logic xen, input logic red, input logic [12:0] cx,
                        input string req, input bit do_wr = 0, input int widx = 0,
                        input logic [63:0] wtg = '0, input logic [63:0] wte = '0);
    @(negedge clk);
    req_valid = 1; req_va = va; req_kind = kind; req_user = usr;
    xlate_en = xen; red_state = red; cur_ctx = cx;
    wr_en = do_wr; wr_idx = 6'(widx); wr_tag = wtg; wr_tte = wte;
    q_d.push_back(ref_lookup(0, va, kind, usr, xen, red, cx, req));
    q_i.push_back(ref_lookup(1, va, kind, usr, xen, red, cx, req));
    if (do_wr) model_write(widx, wtg, wte);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 0; wr_en = 0;
    end
  endtask

  task automatic check_side(input int side);
    logic v, h, f, m;
    logic [40:0] pa;
    logic [2:0] pm;
    logic [63:0] ta;
    exp_t e;
    if (side == 0) begin v = d_valid; h = d_hit; f = d_fault; m = d_miss; pa = d_pa; pm = d_perm; ta = d_ta; end
    else           begin v = i_valid; h = i_hit; f = i_fault; m = i_miss; pa = i_pa; pm = i_perm; ta = i_ta; end
    if (!v) return;
    n_chk++;
    if ((side == 0 && q_d.size() == 0) || (side == 1 && q_i.size() == 0)) begin
      n_bad++;
      $display("FAIL R2 side=%0d: got rsp_valid=1, expected no response", side);
      return;
    end
    e = (side == 0) ? q_d.pop_front() : q_i.pop_front();
    if (pa !== e.pa || h !== e.hit || f !== e.fault || m !== e.miss || pm !== e.perm || ta !== e.ta) begin
      n_bad++;
      $display("FAIL %s side=%0d: got pa=%h hit=%b fault=%b miss=%b perm=%b ta=%h, expected pa=%h hit=%b fault=%b miss=%b perm=%b ta=%h",
               e.req, side, pa, h, f, m, pm, ta, e.pa, e.hit, e.fault, e.miss, e.perm, e.ta);
    end
  endtask

  // monitor: compares responses as they appear
  always @(negedge clk) begin
    #1;
    if (mon_on && !rst) begin
      check_side(0);
      check_side(1);
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  task automatic do_reset;
    mon_on = 0;
    rst = 1; req_valid = 0; wr_en = 0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 64; i++) m_val[i] = 0;
    m_ta[0] = '0; m_ta[1] = '0;
    q_d.delete(); q_i.delete();
    rst = 0;
    @(negedge clk);
    #2;
    n_chk++;
    if (d_valid || d_hit || d_fault || d_miss || d_ta !== 64'd0 || d_pa !== '0 ||
        i_valid || i_hit || i_fault || i_miss || i_ta !== 64'd0 || i_pa !== '0) begin
      n_bad++;
      $display("FAIL R1 reset state: got dv=%b dta=%h iv=%b ita=%h, expected all zero",
               d_valid, d_ta, i_valid, i_ta);
    end
    mon_on = 1;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got no completion, expected end of stimulus");
    report();
    $finish;
  end

  initial begin : stimulus
    logic [63:0] va5, va10, va11, va12, va20, va7, va8, va50;
    rst = 1; wr_en = 0; wr_idx = '0; wr_tag = '0; wr_tte = '0;
    xlate_en = 1; red_state = 0; cur_ctx = CX; req_valid = 0;
    req_va = '0; req_kind = 2'd0; req_user = 0;
    for (int i = 0; i < 64; i++) begin m_tag[i] = '0; m_tte[i] = '0; m_val[i] = 0; end

    do_reset();
    va5  = 64'h0000_0012_3456_A000;
    va10 = 64'h0000_0045_6781_0000;
    va11 = 64'h0000_0078_0008_0000;
    va12 = 64'h0000_0123_0040_0000;
    va20 = 64'h0000_0099_0000_0000;
    va7  = 64'h0000_00AA_0000_2000;
    va8  = 64'h0000_00BB_0000_4000;
    va50 = 64'h0000_00CC_0000_6000;

    lookup(va5, 2'd0, 0, 1, 0, CX, "R1 empty table miss");

    write_entry(5,  mk_tag(va5, CX),  mk_tte(1, 2'd0, 64'h0_1111_2000, 0, 1));
    write_entry(10, mk_tag(va10, CX), mk_tte(1, 2'd1, 64'h2_2222_0000, 0, 1));
    write_entry(11, mk_tag(va11, CX), mk_tte(1, 2'd2, 64'h1_0000_0000 | 64'h7_E000, 0, 1));
    write_entry(12, mk_tag(va12, CX), mk_tte(1, 2'd3, 64'h0FF0_0003_3300_0000 | 64'h1_E000, 0, 1));
    write_entry(40, mk_tag(64'h0000_00DD_0000_0000, CX), mk_tte(0, 2'd0, 64'h5_0000_0000, 0, 1));
    write_entry(20, mk_tag(va20, CX), mk_tte(1, 2'd0, 64'h0_2020_0000, 0, 1));
    write_entry(30, mk_tag(va20, CX), mk_tte(1, 2'd0, 64'h0_3030_0000, 0, 1));
    write_entry(7,  mk_tag(va7, CX),  mk_tte(1, 2'd0, 64'h0_0777_0000, 1, 1));
    write_entry(8,  mk_tag(va8, CX),  mk_tte(1, 2'd0, 64'h0_0888_0000, 0, 0));

    lookup(va5 | 64'h123, 2'd0, 0, 1, 0, CX, "R6 8K hit with offset");
    lookup(va5 | 64'h1FFF, 2'd2, 0, 1, 0, CX, "R6 8K fetch top offset");
    lookup(va10 | 64'hABCD, 2'd0, 0, 1, 0, CX, "R3 64K hit inside page");
    lookup(va10 + 64'h1_0000, 2'd0, 0, 1, 0, CX, "R3 64K next page miss");
    lookup(va11 | 64'h7_F123, 2'd0, 0, 1, 0, CX, "R3 512K hit inside page");
    lookup(va11 + 64'h8_0000, 2'd0, 0, 1, 0, CX, "R3 512K next page miss");
    lookup(va12 | 64'h3F_FFFF, 2'd0, 0, 1, 0, CX, "R6 4M hit high bits cleared");
    lookup(va12 ^ 64'h40_0000, 2'd0, 0, 1, 0, CX, "R3 4M neighbour miss");
    lookup(va5, 2'd0, 0, 1, 0, 13'h0AC, "R5 context mismatch miss");
    lookup(64'h0000_00DD_0000_0010, 2'd0, 0, 1, 0, CX, "R4 invalid entry miss");
    lookup(va20 | 64'h44, 2'd0, 0, 1, 0, CX, "R7 lowest index wins");
    lookup(va7, 2'd0, 1, 1, 0, CX, "R8 user on privileged page fault");
    lookup(va7, 2'd0, 0, 1, 0, CX, "R8 privileged access hit");
    lookup(va8, 2'd1, 0, 1, 0, CX, "R9 R10 store to read-only page");
    lookup(va8, 2'd0, 0, 1, 0, CX, "R9 load read-only page perm");
    lookup(va5, 2'd1, 0, 1, 0, CX, "R9 store to writable page");
    lookup(64'hFFFF_F0EE_DDCC_B123, 2'd0, 0, 0, 0, CX, "R12 translation off bypass");
    lookup(64'h0000_00EE_0000_0000, 2'd0, 0, 1, 1, CX, "R12 red state instr bypass");
    lookup(va5, 2'd0, 0, 1, 1, CX, "R12 red state data translates");
    idle(1);

    write_entry(20, mk_tag(va20, CX), mk_tte(0, 2'd0, 64'h0_2020_0000, 0, 1));
    lookup(va20, 2'd0, 0, 1, 0, CX, "R7 next entry after invalidate");
    lookup(va50, 2'd0, 0, 1, 0, CX, "R13 lookup during write sees old",
           1, 50, mk_tag(va50, CX), mk_tte(1, 2'd0, 64'h0_0555_0000, 0, 1));
    lookup(va50, 2'd0, 0, 1, 0, CX, "R13 lookup after write hits");
    idle(3);

    do_reset();
    lookup(va5, 2'd0, 0, 1, 0, CX, "R1 reset invalidates entries");
    lookup(va10, 2'd1, 1, 1, 0, 13'h1FFF, "R11 miss captures context");
    idle(3);

    n_chk++;
    if (q_d.size() != 0 || q_i.size() != 0) begin
      n_bad++;
      $display("FAIL R2 pending responses: got %0d/%0d outstanding, expected 0/0",
               q_d.size(), q_i.size());
    end
    report();
    $finish;
  end

endmodule